// File: doc/BRIEF.md
# Smart card character receiver

This block receives asynchronous characters from the I/O line of an ISO 7816 smart card. Time is measured in elementary time units (ETU). A programmable count of clocks per ETU sets the ETU length. A falling edge on the idle line starts a character. The block confirms the start bit half an ETU later. It then samples eight data bits and a parity bit, each in the middle of its ETU. The decoded byte goes out on a valid/ready interface together with a parity-error flag.

The convention is held in a status bit: 1 means direct, where a high line is a logic 1 and bits arrive LSB first. 0 means inverse, where levels are inverted and bits arrive MSB first. Reset selects direct. Firmware can arm a one-shot initial-character detector. The next character is then compared with the line patterns of the initial character (0x3B in direct, 0x3F in inverse), and the convention bit is set to match. That character is still delivered as a normal byte. Firmware can also write the convention bit directly.

In T=0 operation, a parity error makes the block pull the line low as an error signal. The pull starts 10.5 ETU after the start edge and lasts for a selectable length. When the block is not signalling, it samples the line at 11 ETU to catch an error signal driven by the card.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, rx_valid is 0, conv_direct is 1 (direct), ts_armed is 0, io_drive_low is 0 and card_break is 0.
- R2: A falling edge on an idle line is counted as clock 0. If the line is high at clock etu_clks/2, the character is dropped and no byte is produced.
- R3: Bit k (1..9 after the start bit) is sampled at clock k*etu_clks + etu_clks/2. The byte appears, with rx_valid high, right after the edge at 9*etu_clks + etu_clks/2. In direct convention, the first data bit is data[0] and a high level reads as 1.
- R4: In inverse convention, the first data bit is data[7], and both data and parity levels are inverted.
- R5: Pulsing arm_ts sets ts_armed. The next character clears it. If that character's first eight line levels (first bit in bit 0) equal 8'h3B, the convention becomes direct. If they equal 8'h03, it becomes inverse. The decoded byte (0x3B or 0x3F) is delivered.
- R6: A conv_wr pulse loads conv_wdata into conv_direct. An update from initial-character detection in the same cycle takes priority.
- R7: Parity is even over the eight data bits plus the parity bit. rx_perr goes with each byte. It is forced to 0 while parity_off is 1.
- R8: io_drive_low rises right after the edge at 10*etu_clks + etu_clks/2, and only for a parity error when t0_mode=1, break_en=1 and parity_off=0.
- R9: brk_len sets how many clocks io_drive_low stays high: 2'b00 gives etu_clks, 2'b01 gives etu_clks + etu_clks/2, and 2'b10 and 2'b11 give 2*etu_clks.
- R10: When no error signal is being driven, card_break pulses for one cycle if the line is low at clock 11*etu_clks.
- R11: After an error signal or a card-break sample, a falling edge is ignored until io_drive_low is low and the line has been seen high.
- R12: rx_valid stays high until a cycle with rx_ready high. A new byte arriving before that replaces the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_clks | input | CNT_W | Clocks per ETU (at least 4) |
| io_in | input | 1 | Sampled card I/O line level |
| io_drive_low | output | 1 | Pulls the I/O line low for the error signal |
| t0_mode | input | 1 | T=0 protocol selected |
| parity_off | input | 1 | Disables parity checking |
| break_en | input | 1 | Allows the error signal on a parity error |
| brk_len | input | 2 | Error-signal length code |
| arm_ts | input | 1 | Pulse: treat the next character as the initial character |
| ts_armed | output | 1 | Initial-character detection pending |
| conv_wr | input | 1 | Pulse: write the convention bit |
| conv_wdata | input | 1 | Convention value to write (1 = direct) |
| conv_direct | output | 1 | Current convention (1 = direct, 0 = inverse) |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error for rx_data |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer accepts the byte |
| card_break | output | 1 | One-cycle pulse: card error signal seen |

## Verification
The bench targets the following corner cases:
- **Short glitch.** A design that skips the half-ETU recheck would produce a phantom byte.
- **Both initial-character line patterns, plus a later inverse byte.** Reversing the bit order or dropping the level inversion would corrupt the byte and flip the convention the wrong way.
- **Every error-signal length code, including the reserved one.** A wrong offset or length would show up both in the clock-by-clock comparison and in the measured pulse width.
- **Low line held through the end of the signal.** A receiver that re-arms too early would decode a false character from the card's own low level.
- **Card break at the guard sample.** This must produce exactly one pulse.
- **Two bytes with rx_ready low.** This exercises the overwrite rule.
- **Two ETU lengths.** A design that rounds the half-ETU point wrongly would sample off-centre.

// File: rtl/sc_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants of the smart card character receiver.
// Assumes the character layout: start bit, eight data bits, one parity bit.
package sc_rx_pkg;

    // Receiver sequencing: waiting for an edge, inside a character, holding off
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_BITS = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_e;

    // Error-signal length codes
    typedef enum logic [1:0] {
        BRK_ONE      = 2'b00,
        BRK_ONE_HALF = 2'b01,
        BRK_TWO      = 2'b10,
        BRK_RSVD     = 2'b11
    } brk_len_e;

    localparam int IDX_W = 4;
    // ETU indices at which the sequencing acts (start bit is index 0)
    localparam logic [IDX_W-1:0] IDX_PAR   = 4'd9;
    localparam logic [IDX_W-1:0] IDX_BRK   = 4'd10;
    localparam logic [IDX_W-1:0] IDX_GUARD = 4'd11;

    // Raw line levels of the initial character, first received bit in bit 0
    localparam logic [7:0] TS_RAW_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_RAW_INVERSE = 8'h03;

endpackage

// File: rtl/sc_etu_timer.sv
`timescale 1ns/1ps
// ETU timer: counts clocks within the current ETU (phase) and the ETU index
// since the start edge. A start pulse marks clock 0 of a character.
// Assumes etu_clks >= 4 so the half-ETU point is distinct from phase 0.
module sc_etu_timer
    import sc_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] etu_clks,
    input  logic             start,
    input  logic             run,
    output logic [IDX_W-1:0] idx,
    output logic             at_mid,
    output logic             at_zero
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] half;

    // Half-ETU point
    assign half = etu_clks >> 1;

    // Phase and index counting; the index saturates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            idx   <= '0;
        end else if (start) begin
            phase <= ONE;
            idx   <= '0;
        end else if (run) begin
            if (phase == etu_clks - ONE) begin
                phase <= '0;
                if (idx != '1) idx <= idx + IDX_ONE;
            end else begin
                phase <= phase + ONE;
            end
        end
    end

    // Event strobes for the sequencing logic
    assign at_mid  = (phase == half);
    assign at_zero = (phase == '0);

endmodule

// File: rtl/sc_char_decode.sv
`timescale 1ns/1ps
// Character decoder: turns nine raw line levels (first bit in bit 0, parity
// in bit 8) into a byte and a parity verdict. When initial-character
// detection is armed, the raw pattern picks the convention.
// Purely combinational.
module sc_char_decode
    import sc_rx_pkg::*;
(
    input  logic [8:0] raw,
    input  logic       direct,
    input  logic       ts_armed,
    output logic [7:0] data,
    output logic       par_err,
    output logic       ts_hit,
    output logic       ts_direct
);
    logic [7:0] inv_bits;
    logic       use_direct;
    logic       par_bit;
    logic       hit_dir;
    logic       hit_inv;

    // Inverse convention: reversed order, inverted levels
    for (genvar i = 0; i < 8; i++) begin : g_inv
        assign inv_bits[i] = ~raw[7-i];
    end

    // Initial-character match and convention choice
    always_comb begin
        hit_dir    = ts_armed && (raw[7:0] == TS_RAW_DIRECT);
        hit_inv    = ts_armed && (raw[7:0] == TS_RAW_INVERSE);
        use_direct = hit_dir ? 1'b1 : (hit_inv ? 1'b0 : direct);
    end

    // Data, parity and verdict
    always_comb begin
        data      = use_direct ? raw[7:0] : inv_bits;
        par_bit   = use_direct ? raw[8] : ~raw[8];
        par_err   = ^{data, par_bit};
        ts_hit    = hit_dir || hit_inv;
        ts_direct = hit_dir;
    end

endmodule

// File: rtl/sc_break_gen.sv
`timescale 1ns/1ps
// Error-signal generator: on start, holds busy high for the selected number
// of clocks (one, one and a half or two ETU; the reserved code acts as two).
module sc_break_gen
    import sc_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] etu_clks,
    input  logic [1:0]       len_sel,
    output logic             busy
);
    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] LONE = LEN_W'(1);

    logic [LEN_W-1:0] etu_w;
    logic [LEN_W-1:0] half_w;
    logic [LEN_W-1:0] len_clks;
    logic [LEN_W-1:0] cnt;

    // Length selection in clocks
    always_comb begin
        etu_w  = {1'b0, etu_clks};
        half_w = {2'b00, etu_clks[CNT_W-1:1]};
        case (brk_len_e'(len_sel))
            BRK_ONE:      len_clks = etu_w;
            BRK_ONE_HALF: len_clks = etu_w + half_w;
            default:      len_clks = etu_w << 1;
        endcase
    end

    // Down-counter of remaining drive clocks
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= len_clks;
        else if (cnt != '0)  cnt <= cnt - LONE;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/sc_char_rx.sv
`timescale 1ns/1ps
// Smart card character receiver top. Detects and confirms the start bit,
// samples nine bits mid-ETU, decodes them in the current convention (or
// learns it from the initial character), presents the byte on a
// valid/ready port, drives the T=0 parity error signal and samples a card
// error signal at 11 ETU. Assumes io_in is already synchronous to clk and
// etu_clks only changes while the line is idle.
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] etu_clks,
    input  logic             io_in,
    output logic             io_drive_low,
    input  logic             t0_mode,
    input  logic             parity_off,
    input  logic             break_en,
    input  logic [1:0]       brk_len,
    input  logic             arm_ts,
    output logic             ts_armed,
    input  logic             conv_wr,
    input  logic             conv_wdata,
    output logic             conv_direct,
    output logic [7:0]       rx_data,
    output logic             rx_perr,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             card_break
);
    rx_state_e        state;
    logic             io_q;
    logic [IDX_W-1:0] idx;
    logic             at_mid, at_zero;
    logic [7:0]       shift_q;
    logic             brk_pend, brk_busy;
    logic             in_bits, start_det, false_start, bit_take;
    logic             char_done, brk_fire, guard_chk;
    logic [7:0]       dec_data;
    logic             dec_perr, ts_hit, ts_dir, perr_seen, want_brk;

    // Previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) io_q <= 1'b1;
        else        io_q <= io_in;
    end

    // Event decode from state and timer strobes
    always_comb begin
        in_bits     = (state == RX_BITS);
        start_det   = (state == RX_IDLE) && io_q && !io_in;
        false_start = in_bits && at_mid && (idx == '0) && io_in;
        bit_take    = in_bits && at_mid && (idx != '0) && (idx < IDX_PAR);
        char_done   = in_bits && at_mid && (idx == IDX_PAR);
        brk_fire    = in_bits && at_mid && (idx == IDX_BRK) && brk_pend;
        guard_chk   = in_bits && at_zero && (idx == IDX_GUARD) && !brk_pend;
        perr_seen   = dec_perr && !parity_off;
        want_brk    = perr_seen && t0_mode && break_en;
    end

    sc_etu_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .etu_clks (etu_clks),
        .start    (start_det),
        .run      (in_bits),
        .idx      (idx),
        .at_mid   (at_mid),
        .at_zero  (at_zero)
    );

    sc_char_decode u_decode (
        .raw       ({io_in, shift_q}),
        .direct    (conv_direct),
        .ts_armed  (ts_armed),
        .data      (dec_data),
        .par_err   (dec_perr),
        .ts_hit    (ts_hit),
        .ts_direct (ts_dir)
    );

    sc_break_gen #(.CNT_W(CNT_W)) u_break (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (brk_fire),
        .etu_clks (etu_clks),
        .len_sel  (brk_len),
        .busy     (brk_busy)
    );

    assign io_drive_low = brk_busy;

    // Sequencing between idle, character and hold-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            case (state)
                RX_IDLE: if (start_det) state <= RX_BITS;
                RX_BITS: begin
                    if (false_start)               state <= RX_IDLE;
                    else if (brk_fire || guard_chk) state <= RX_HOLD;
                end
                RX_HOLD: if (!brk_busy && io_in) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Collect data bits, first bit ends in bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (bit_take) shift_q <= {io_in, shift_q[7:1]};
    end

    // Remember whether this character needs an error signal
    always_ff @(posedge clk) begin
        if (!rst_n)         brk_pend <= 1'b0;
        else if (start_det) brk_pend <= 1'b0;
        else if (char_done) brk_pend <= want_brk;
    end

    // Byte output register with valid/ready handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
        end else if (char_done) begin
            rx_valid <= 1'b1;
            rx_data  <= dec_data;
            rx_perr  <= perr_seen;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // Card error signal sample at 11 ETU
    always_ff @(posedge clk) begin
        if (!rst_n) card_break <= 1'b0;
        else        card_break <= guard_chk && !io_in;
    end

    // One-shot initial-character detection flag
    always_ff @(posedge clk) begin
        if (!rst_n)         ts_armed <= 1'b0;
        else if (arm_ts)    ts_armed <= 1'b1;
        else if (char_done) ts_armed <= 1'b0;
    end

    // Convention bit: detection update first, then firmware write
    always_ff @(posedge clk) begin
        if (!rst_n)                    conv_direct <= 1'b1;
        else if (char_done && ts_hit)  conv_direct <= ts_dir;
        else if (conv_wr)              conv_direct <= conv_wdata;
    end

endmodule

// File: rtl/sc_char_rx_chk.sv
`timescale 1ns/1ps
// Checker for sc_char_rx: port-level temporal properties, bound to the top.
module sc_char_rx_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] etu_clks,
    input logic             io_drive_low,
    input logic             t0_mode,
    input logic             parity_off,
    input logic             break_en,
    input logic             ts_armed,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             card_break
);
    logic [CNT_W+1:0] drv_run;

    // Length of the current error signal in clocks
    always_ff @(posedge clk) begin
        if (!rst_n)            drv_run <= '0;
        else if (io_drive_low) drv_run <= drv_run + (CNT_W+2)'(1);
        else                   drv_run <= '0;
    end

    // R12
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid);

    // R8
    brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_drive_low) |-> t0_mode && break_en && !parity_off);

    // R9
    brk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_run <= ({2'b00, etu_clks} << 1));

    // R10
    card_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_break |=> !card_break);

    // R5
    ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_armed) |-> rx_valid);

    // R11
    no_rx_in_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive_low |-> !card_break);

endmodule

bind sc_char_rx sc_char_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .etu_clks     (etu_clks),
    .io_drive_low (io_drive_low),
    .t0_mode      (t0_mode),
    .parity_off   (parity_off),
    .break_en     (break_en),
    .ts_armed     (ts_armed),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .card_break   (card_break)
);

// File: tb/sc_char_rx_tb.sv
`timescale 1ns/1ps
// Bench for sc_char_rx: behavioural model compared on every clock, plus
// scenario checks on delivered bytes and error-signal lengths.
module sc_char_rx_tb;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    int               cfg_e = 8;
    logic [CNT_W-1:0] etu_clks;
    logic             card_lvl = 1'b1;
    logic             io_line;
    logic             io_drive_low;
    logic             t0_mode = 1'b0, parity_off = 1'b0, break_en = 1'b0;
    logic [1:0]       brk_len = 2'b00;
    logic             arm_ts = 1'b0, ts_armed;
    logic             conv_wr = 1'b0, conv_wdata = 1'b0, conv_direct;
    logic [7:0]       rx_data;
    logic             rx_perr, rx_valid;
    logic             rx_ready = 1'b1;
    logic             card_break;

    assign etu_clks = CNT_W'(cfg_e);
    assign io_line  = card_lvl & ~io_drive_low;

    always #10 clk = ~clk;

    sc_char_rx #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .etu_clks(etu_clks), .io_in(io_line),
        .io_drive_low(io_drive_low), .t0_mode(t0_mode), .parity_off(parity_off),
        .break_en(break_en), .brk_len(brk_len), .arm_ts(arm_ts), .ts_armed(ts_armed),
        .conv_wr(conv_wr), .conv_wdata(conv_wdata), .conv_direct(conv_direct),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .card_break(card_break)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [8:0] byte_q[$];
    int drv_cycles = 0, cb_count = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Line levels for a byte in a convention, optionally with bad parity
    function automatic logic [8:0] enc(input logic [7:0] d, input bit dirc, input bit bad);
        logic [8:0] r;
        logic p;
        for (int i = 0; i < 8; i++) r[i] = dirc ? d[i] : ~d[7-i];
        p = (^d) ^ bad;
        r[8] = dirc ? p : ~p;
        return r;
    endfunction

    // ---------------- behavioural reference model ----------------
    int         m_st, m_c, m_brk;
    logic       m_prev, m_valid, m_perr, m_arm, m_conv, m_drv, m_cb, m_pend;
    logic [7:0] m_data, m_bits;

    always @(posedge clk) begin
        int e, h, blen;
        logic line, prv, use_dir, hit, ts_done, pe;
        logic [8:0] r, tsd, tsi;
        logic [7:0] d;
        e = cfg_e; h = cfg_e / 2;
        blen = (brk_len == 2'b00) ? e : (brk_len == 2'b01) ? e + h : 2 * e;
        tsd = enc(8'h3B, 1'b1, 1'b0);
        tsi = enc(8'h3F, 1'b0, 1'b0);
        if (!rst_n) begin
            m_st = 0; m_c = 0; m_brk = 0; m_prev = 1; m_valid = 0; m_perr = 0;
            m_arm = 0; m_conv = 1; m_drv = 0; m_cb = 0; m_pend = 0;
            m_data = 0; m_bits = 0;
        end else begin
            line = io_line; prv = m_prev; m_prev = line;
            ts_done = 0; hit = 0; use_dir = m_conv;
            m_cb = 0;
            if (m_valid && rx_ready) m_valid = 0;
            case (m_st)
                0: if (prv && !line) begin m_st = 1; m_c = 1; m_pend = 0; end
                1: begin
                    if (m_c == h && line) m_st = 0;
                    for (int k = 1; k <= 8; k++)
                        if (m_c == k * e + h) m_bits[k-1] = line;
                    if (m_c == 9 * e + h) begin
                        r = {line, m_bits};
                        if (m_arm) begin
                            ts_done = 1;
                            if (r[7:0] == tsd[7:0])      begin use_dir = 1; hit = 1; end
                            else if (r[7:0] == tsi[7:0]) begin use_dir = 0; hit = 1; end
                        end
                        for (int i = 0; i < 8; i++) d[i] = use_dir ? r[i] : ~r[7-i];
                        pe = (^d) ^ (use_dir ? r[8] : ~r[8]);
                        m_valid = 1; m_data = d; m_perr = pe && !parity_off;
                        m_pend = pe && !parity_off && t0_mode && break_en;
                        if (hit) m_conv = use_dir;
                    end
                    if (m_c == 10 * e + h && m_pend) begin
                        m_st = 2; m_drv = 1; m_brk = blen;
                    end else if (m_c == 11 * e && !m_pend) begin
                        m_cb = !line; m_st = 3;
                    end
                    m_c++;
                end
                2: begin
                    m_brk--;
                    if (m_brk == 0) begin m_drv = 0; m_st = 3; end
                end
                default: if (line) m_st = 0;
            endcase
            if (arm_ts) m_arm = 1; else if (ts_done) m_arm = 0;
            if (!hit && conv_wr) m_conv = conv_wdata;
        end
    end

    // Clock-by-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(rx_valid === m_valid, "R12", "rx_valid", int'(rx_valid), int'(m_valid));
            if (m_valid) begin
                chk(rx_data === m_data, "R3", "rx_data", int'(rx_data), int'(m_data));
                chk(rx_perr === m_perr, "R7", "rx_perr", int'(rx_perr), int'(m_perr));
            end
            chk(ts_armed === m_arm, "R5", "ts_armed", int'(ts_armed), int'(m_arm));
            chk(conv_direct === m_conv, "R6", "conv_direct", int'(conv_direct), int'(m_conv));
            chk(io_drive_low === m_drv, "R8", "io_drive_low", int'(io_drive_low), int'(m_drv));
            chk(card_break === m_cb, "R10", "card_break", int'(card_break), int'(m_cb));
            if (rx_valid && rx_ready) byte_q.push_back({rx_perr, rx_data});
            if (io_drive_low) drv_cycles++;
            if (card_break) cb_count++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic hold(input logic lvl, input int n);
        card_lvl = lvl;
        repeat (n) @(negedge clk);
    endtask

    // tail 1: card pulls low over the 11 ETU sample; tail 2: long low after a break
    task automatic send(input logic [8:0] raw, input int tail);
        hold(1'b0, cfg_e);
        for (int i = 0; i < 9; i++) hold(raw[i], cfg_e);
        if (tail == 1) begin hold(1'b1, cfg_e / 2); hold(1'b0, cfg_e); end
        if (tail == 2) begin hold(1'b1, cfg_e / 2 + 1); hold(1'b0, 3 * cfg_e); end
        hold(1'b1, 4 * cfg_e);
    endtask

    task automatic expect_byte(input logic [7:0] d, input logic pe, input string req);
        logic [8:0] v;
        if (byte_q.size() == 0) begin
            chk(1'b0, req, "byte count", 0, 1);
        end else begin
            v = byte_q.pop_front();
            chk(v[7:0] == d, req, "byte data", int'(v[7:0]), int'(d));
            chk(v[8] == pe, req, "byte perr", int'(v[8]), int'(pe));
        end
    endtask

    task automatic pulse_arm();
        arm_ts = 1'b1; @(negedge clk); arm_ts = 1'b0; @(negedge clk);
    endtask

    task automatic write_conv(input logic v);
        conv_wdata = v; conv_wr = 1'b1; @(negedge clk); conv_wr = 1'b0; @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_valid == 0, "R1", "rx_valid", int'(rx_valid), 0);
        chk(conv_direct == 1, "R1", "conv_direct", int'(conv_direct), 1);
        chk(ts_armed == 0, "R1", "ts_armed", int'(ts_armed), 0);
        chk(io_drive_low == 0 && card_break == 0, "R1", "drive/cb",
            int'({io_drive_low, card_break}), 0);
        hold(1'b1, 2 * cfg_e);

        // R3 direct byte
        send(enc(8'hA5, 1'b1, 1'b0), 0);
        expect_byte(8'hA5, 1'b0, "R3");

        // R2 glitch shorter than half an ETU
        hold(1'b0, 2); hold(1'b1, 4 * cfg_e);
        chk(byte_q.size() == 0, "R2", "glitch bytes", byte_q.size(), 0);

        // R5 inverse initial character, then R4 inverse byte
        pulse_arm();
        chk(ts_armed == 1, "R5", "armed", int'(ts_armed), 1);
        send(enc(8'h3F, 1'b0, 1'b0), 0);
        expect_byte(8'h3F, 1'b0, "R5");
        chk(conv_direct == 0, "R5", "conv after inverse", int'(conv_direct), 0);
        chk(ts_armed == 0, "R5", "arm cleared", int'(ts_armed), 0);
        send(enc(8'h5C, 1'b0, 1'b0), 0);
        expect_byte(8'h5C, 1'b0, "R4");

        // R6 firmware write, then R5 direct initial character
        write_conv(1'b1);
        chk(conv_direct == 1, "R6", "conv write 1", int'(conv_direct), 1);
        write_conv(1'b0);
        chk(conv_direct == 0, "R6", "conv write 0", int'(conv_direct), 0);
        pulse_arm();
        send(enc(8'h3B, 1'b1, 1'b0), 0);
        expect_byte(8'h3B, 1'b0, "R5");
        chk(conv_direct == 1, "R5", "conv after direct", int'(conv_direct), 1);

        // R8 and R9: error signal for each length code
        t0_mode = 1'b1; break_en = 1'b1;
        for (int len = 0; len < 4; len++) begin
            brk_len = 2'(len);
            drv_cycles = 0;
            send(enc(8'h96, 1'b1, 1'b1), 0);
            expect_byte(8'h96, 1'b1, "R7");
            chk(drv_cycles == ((len == 0) ? cfg_e : (len == 1) ? cfg_e + cfg_e / 2 : 2 * cfg_e),
                "R9", "break clocks", drv_cycles,
                (len == 0) ? cfg_e : (len == 1) ? cfg_e + cfg_e / 2 : 2 * cfg_e);
        end

        // R7 parity disabled: no flag, no error signal
        parity_off = 1'b1; drv_cycles = 0;
        send(enc(8'h96, 1'b1, 1'b1), 0);
        expect_byte(8'h96, 1'b0, "R7");
        chk(drv_cycles == 0, "R8", "break with parity off", drv_cycles, 0);
        parity_off = 1'b0;

        // R8 outside T=0: flag but no error signal
        t0_mode = 1'b0; drv_cycles = 0;
        send(enc(8'h41, 1'b1, 1'b1), 0);
        expect_byte(8'h41, 1'b1, "R8");
        chk(drv_cycles == 0, "R8", "break outside T0", drv_cycles, 0);

        // R10 card error signal at 11 ETU
        cb_count = 0;
        send(enc(8'h12, 1'b1, 1'b0), 1);
        expect_byte(8'h12, 1'b0, "R10");
        chk(cb_count == 1, "R10", "card break pulses", cb_count, 1);

        // R11 low line outlasting the error signal is no new character
        t0_mode = 1'b1; brk_len = 2'b00;
        send(enc(8'h77, 1'b1, 1'b1), 2);
        expect_byte(8'h77, 1'b1, "R11");
        chk(byte_q.size() == 0, "R11", "extra bytes", byte_q.size(), 0);
        send(enc(8'h0F, 1'b1, 1'b0), 0);
        expect_byte(8'h0F, 1'b0, "R11");
        t0_mode = 1'b0; break_en = 1'b0;

        // R12 hold and overwrite while not ready
        rx_ready = 1'b0;
        send(enc(8'h11, 1'b1, 1'b0), 0);
        chk(rx_valid == 1 && rx_data == 8'h11, "R12", "held byte", int'(rx_data), 8'h11);
        send(enc(8'h22, 1'b1, 1'b0), 0);
        chk(rx_valid == 1 && rx_data == 8'h22, "R12", "overwritten byte", int'(rx_data), 8'h22);
        rx_ready = 1'b1;
        @(negedge clk); @(negedge clk);
        expect_byte(8'h22, 1'b0, "R12");

        // R3 and R4 with a different ETU length
        cfg_e = 10;
        hold(1'b1, 2 * cfg_e);
        send(enc(8'hC4, 1'b1, 1'b0), 0);
        expect_byte(8'hC4, 1'b0, "R3");
        write_conv(1'b0);
        send(enc(8'h6A, 1'b0, 1'b0), 0);
        expect_byte(8'h6A, 1'b0, "R4");

        chk(byte_q.size() == 0, "R2", "leftover bytes", byte_q.size(), 0);
        summary();
    end

endmodule